// File: doc/BRIEF.md
# Acquisition Sample Byte Packetizer

The packetizer turns acquired samples into a byte stream for a host link. It takes two kinds of input, each with a valid/ready handshake. The first kind is analog conversions: a 12-bit value tagged with a 4-bit channel number. The second kind is snapshots of a 12-bit digital input bank. Each sample is cut into 4-bit nibbles and placed in 8-bit bytes. Each byte also carries a type flag and a small reassembly index, so the host can rebuild the value. The output is a byte stream with its own valid/ready handshake, meant to feed a transmit FIFO that drains to a serial or parallel link.

Analog samples open with a channel header byte. Digital snapshots have no header. A sample always leaves as an unbroken run of bytes. New samples are refused until the final byte of the current one has been taken.

Top module: `sample_byte_packer`

## Requirements
- R1: Bit 7 of every output byte gives the sample type: 1 for analog, 0 for digital.
- R2: An accepted analog sample produces four bytes in this order. The first is a header byte `{4'b1111, channel}`. It is followed by three data bytes `{1'b1, idx, nibble}` with idx 0, 1, 2, carrying data bits [3:0], [7:4] and [11:8] in that order.
- R3: An accepted digital snapshot produces exactly three bytes `{1'b0, idx, nibble}` with idx 0, 1, 2, carrying bits [3:0], [7:4] and [11:8] in that order. It has no header byte.
- R4: An analog data byte never carries index 111. The byte that follows a taken header byte is always the analog data byte with index 000.
- R5: If analog and digital inputs are both valid while the block is idle, the analog sample is accepted and the digital ready output stays low.
- R6: Both input ready outputs stay low from the accepting cycle until the last byte of that sample has been taken. No input handshake happens while output valid is high.
- R7: While output valid is high and output ready is low, the output byte and output valid hold steady. The byte sequence then continues with no lost and no repeated byte.
- R8: A synchronous active-high reset deasserts output valid on the next cycle and discards any partly sent sample. The first sample accepted after reset starts from its first byte.
- R9: The header's channel field passes all 16 channel numbers 0 to 15 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ana_valid | input | 1 | Analog sample offered |
| ana_ready | output | 1 | Analog sample can be accepted |
| ana_chan | input | 4 | Channel of the analog sample |
| ana_data | input | 12 | Analog sample value |
| dig_valid | input | 1 | Digital snapshot offered |
| dig_ready | output | 1 | Digital snapshot can be accepted |
| dig_data | input | 12 | Digital input bank snapshot |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Packed output byte |

## Verification
The bench aims at the following corner cases:
- **Simultaneous inputs.** Both inputs are raised together. A design that checks the digital input first, or accepts both, would emit digital bytes first or merge the two streams.
- **Backpressure.** Long and irregular backpressure is applied in the middle of samples. A design that advances on valid alone would skip or repeat nibbles.
- **Nibble order.** Nibble values are chosen so that order errors show. A design that sent the most significant nibble first, or reused index 111, would produce different bytes.
- **Reset mid-sample.** Reset is applied partway through a sample. A design that kept its byte position across reset would resume an abandoned sample.
- **Header channels.** All sixteen channel numbers are driven, which catches a truncated or swapped header field.

// File: rtl/sample_byte_packer.sv
module sample_byte_packer #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ana_valid,
  output logic                ana_ready,
  input  logic [3:0]          ana_chan,
  input  logic [SAMPLE_W-1:0] ana_data,
  input  logic                dig_valid,
  output logic                dig_ready,
  input  logic [SAMPLE_W-1:0] dig_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_byte
);
  localparam int NIBS = SAMPLE_W / 4;
  localparam logic [2:0] LAST_IDX = 3'(NIBS - 1);

  logic                busy, is_ana, hdr_pend;
  logic [2:0]          step;
  logic [3:0]          chan;
  logic [SAMPLE_W-1:0] shreg;

  wire take = busy && out_ready;
  wire last = !hdr_pend && (step == LAST_IDX);

  assign ana_ready = !busy;
  assign dig_ready = !busy && !ana_valid;
  assign out_valid = busy;
  assign out_byte  = hdr_pend ? {4'hF, chan} : {is_ana, step, shreg[3:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      is_ana   <= 1'b0;
      hdr_pend <= 1'b0;
      step     <= '0;
      chan     <= '0;
      shreg    <= '0;
    end else if (!busy) begin
      step <= '0;
      if (ana_valid) begin
        busy     <= 1'b1;
        is_ana   <= 1'b1;
        hdr_pend <= 1'b1;
        chan     <= ana_chan;
        shreg    <= ana_data;
      end else if (dig_valid) begin
        busy     <= 1'b1;
        is_ana   <= 1'b0;
        hdr_pend <= 1'b0;
        shreg    <= dig_data;
      end
    end else if (take) begin
      if (hdr_pend) begin
        hdr_pend <= 1'b0;
      end else if (last) begin
        busy <= 1'b0;
      end else begin
        step  <= step + 3'd1;
        shreg <= shreg >> 4;
      end
    end
  end
endmodule

module sample_byte_packer_chk (
  input logic       clk,
  input logic       rst,
  input logic       ana_valid,
  input logic       ana_ready,
  input logic       dig_valid,
  input logic       dig_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  assert_hdr_then_idx0_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_byte[7:4] == 4'hF |=> out_valid && out_byte[7:4] == 4'h8);

  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(ana_valid && ana_ready) && !(dig_valid && dig_ready));

  assert_analog_first_R5: assert property (@(posedge clk) disable iff (rst)
    ana_valid && dig_valid |-> !dig_ready);

  assert_dig_idx_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_byte[7] |-> out_byte[6:4] <= 3'd2);

  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind sample_byte_packer sample_byte_packer_chk u_chk (
  .clk(clk), .rst(rst), .ana_valid(ana_valid), .ana_ready(ana_ready),
  .dig_valid(dig_valid), .dig_ready(dig_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/sim_sample_byte_packer.sv
module sim_sample_byte_packer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ana_valid = 1'b0, dig_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] ana_chan = '0;
  logic [11:0] ana_data = '0, dig_data = '0;
  logic ana_ready, dig_ready, out_valid;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  sample_byte_packer u0 (
    .clk(clk), .rst(rst), .ana_valid(ana_valid), .ana_ready(ana_ready),
    .ana_chan(ana_chan), .ana_data(ana_data), .dig_valid(dig_valid),
    .dig_ready(dig_ready), .dig_data(dig_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [15:0] chan_seen = '0;
  logic ana_fire = 1'b0, dig_fire = 1'b0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    ana_fire = 1'b0;
    dig_fire = 1'b0;
    if (rst) begin
      exp_q.delete();
      tag_q.delete();
    end else begin
      check("R7 out_valid", int'(out_valid), int'(exp_q.size() != 0));
      check("R6 ana_ready", int'(ana_ready), int'(exp_q.size() == 0));
      check("R5 dig_ready", int'(dig_ready), int'(exp_q.size() == 0 && !ana_valid));
      if (exp_q.size() != 0) begin
        check({tag_q[0], " R1 byte"}, int'(out_byte), int'(exp_q[0]));
        if (out_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (ana_valid) begin
        ana_fire = 1'b1;
        chan_seen[ana_chan] = 1'b1;
        exp_q.push_back({4'hF, ana_chan}); tag_q.push_back("R2 R9 header");
        for (int k = 0; k < 3; k++) begin
          exp_q.push_back({1'b1, 3'(k), ana_data[4*k +: 4]});
          tag_q.push_back("R2 R4 analog data");
        end
      end else if (dig_valid) begin
        dig_fire = 1'b1;
        for (int k = 0; k < 3; k++) begin
          exp_q.push_back({1'b0, 3'(k), dig_data[4*k +: 4]});
          tag_q.push_back("R3 digital data");
        end
      end
    end
  end

  task automatic step(input int p_ana, input int p_dig, input int p_rdy);
    @(posedge clk); #1;
    if (ana_fire || !ana_valid) begin
      ana_valid = ($urandom % 100) < p_ana;
      ana_chan  = 4'($urandom);
      ana_data  = 12'($urandom);
    end
    if (dig_fire || !dig_valid) begin
      dig_valid = ($urandom % 100) < p_dig;
      dig_data  = 12'($urandom);
    end
    out_ready = ($urandom % 100) < p_rdy;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset out_valid", int'(out_valid), 0);
    rst = 1'b0;
    out_ready = 1'b1;
    ana_valid = 1'b1; ana_chan = 4'hF; ana_data = 12'hABC;
    dig_valid = 1'b1; dig_data = 12'h5A3;
    @(posedge clk); #1;
    ana_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    dig_valid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    ana_valid = 1'b1; ana_chan = 4'h0; ana_data = 12'h123;
    @(posedge clk); #1;
    ana_valid = 1'b0;
    repeat (8) @(posedge clk);
    for (int i = 0; i < 3000; i++) step(50, 50, 40);
    #1;
    ana_valid = 1'b1; ana_chan = 4'h7; ana_data = 12'hFED;
    dig_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1;
    ana_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8 out_valid after reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 3000; i++) step(60, 60, 70);
    for (int i = 0; i < 1000; i++) step(90, 90, 10);
    #1;
    ana_valid = 1'b0; dig_valid = 1'b0; out_ready = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    check("R9 all channels seen", int'(chan_seen), 16'hFFFF);
    check("R6 drained", int'(out_valid), 0);
    finish_run();
  end
endmodule